// File: doc/BRIEF.md
# Three-Level PWM Gate Drive Sequencer

This block sits between a multiphase controller's three-level PWM command and the gate drivers of one synchronous buck phase. The PWM pin has already been sliced by analog comparators into a two-bit code meaning low, high or mid-level. The block turns that code, a low-side enable, a supply-ready flag and a high-side inhibit from fault logic into two registered, never-overlapping gate enables for the high-side and low-side switches.

A mid-level command parks both switches, but only after it has lasted for a hold-off number of clock cycles. A shorter excursion leaves the gates exactly as they were. When the code leaves the mid-level window, the new command takes effect at once. Turn-off is immediate. A switch turns on only after its request has been present, with both gates off, for a per-side number of cycles. This spacing provides the break-before-make gap and the exit delay from the parked state. The gates stay off until the supply-ready flag has been high for a qualification count. Fault logic can keep the high side off without touching the low side.

Top module: `tsg_gate_ctrl`

## Requirements
- R1: `pwm_code` is decoded as follows: 2'b00 is low, 2'b01 is high, and any code with bit 1 set is mid-level. With a low command accepted and `ls_enable`=1, `gate_ls` turns on. With a low command and `ls_enable`=0, both gates are off.
- R2: With a high command accepted, `gate_hs` turns on whatever `ls_enable` is, and `gate_ls` is off.
- R3: A mid-level code sampled on HOLDOFF_CYC consecutive edges sets the accepted command to "park" on the last of those edges. The gates then turn off on the following edge. A mid-level run that is shorter leaves both gates unchanged.
- R4: A low or high code replaces the accepted command on the first edge at which it is sampled, with no hold-off.
- R5: `gate_hs` and `gate_ls` are never high together. A gate rises only in a cycle where the opposite gate was low in the previous cycle.
- R6: A gate turns off on the first edge at which its request is absent. The high gate turns on at the HS_ON_CYC-th consecutive edge at which it is requested while both gates are off. The low gate uses LS_ON_CYC in the same way.
- R7: Internal readiness rises on the QUAL_CYC-th consecutive edge with `supply_ok`=1, and both gates stay off until then. When `supply_ok` falls, readiness drops on the next edge and the gates turn off on the edge after that.
- R8: With `hs_inhibit` high at an edge, `gate_hs` is low after that edge. The low side keeps following a low command.
- R9: Reset (`rst_n` low) forces both gates off, clears readiness, and sets the accepted command to park.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_code | input | 2 | Sliced PWM level: 00 low, 01 high, 1x mid |
| ls_enable | input | 1 | Low-side enable; 0 keeps the low gate off |
| hs_inhibit | input | 1 | Fault-logic high-side inhibit |
| supply_ok | input | 1 | Supply power-on-ready flag |
| gate_hs | output | 1 | High-side gate enable |
| gate_ls | output | 1 | Low-side gate enable |

## Verification
The delicate overlap is a mid-level hold-off that expires in the same cycle as a break-before-make wait or a change of the inhibit or enable inputs. A mid-level run of exactly HOLDOFF_CYC cycles can end just as a gate would have turned on, and a run one cycle shorter must leave a turning-on gate undisturbed. The bench provokes both cases with directed runs of HOLDOFF_CYC-1 and HOLDOFF_CYC mid cycles. It then adds random run lengths from 1 to 8 cycles, mixed with random inhibit, enable and supply drops. Every cycle is judged against a bench-side cycle model of the requirements, and the bench also checks independently for gate overlap and for a gate rising after a cycle with the other gate high.

// File: rtl/tsg_pkg.sv
package tsg_pkg;

    typedef enum logic [1:0] {
        CMD_OFF  = 2'd0,
        CMD_LOW  = 2'd1,
        CMD_HIGH = 2'd2
    } drive_cmd_e;

    localparam logic [1:0] PWM_HIGH = 2'b01;
    localparam int         MID_BIT  = 1;

endpackage

// File: rtl/tsg_ready_qual.sv
module tsg_ready_qual #(
    parameter int unsigned QUAL_CYC = 15625
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    output logic ready
);
    localparam int unsigned CW = $clog2(QUAL_CYC + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          rdy;
    } qual_st_t;

    qual_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!supply_ok) begin
            s_d.cnt = '0;
            s_d.rdy = 1'b0;
        end else begin
            if (s_q.cnt != CW'(QUAL_CYC)) begin
                s_d.cnt = s_q.cnt + CW'(1);
            end
            s_d.rdy = (s_d.cnt == CW'(QUAL_CYC));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ready = s_q.rdy;

    // R7: supply loss removes readiness on the next edge
    a_r7_supply_drop: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> !ready);

    // R7: readiness only rises while the supply flag was held
    a_r7_rise_needs_supply: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(supply_ok));

endmodule

// File: rtl/tsg_mid_filter.sv
module tsg_mid_filter
    import tsg_pkg::*;
#(
    parameter int unsigned HOLDOFF_CYC = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] pwm_code,
    output drive_cmd_e cmd
);
    localparam int unsigned HW = $clog2(HOLDOFF_CYC + 1);

    typedef struct packed {
        logic [HW-1:0] cnt;
        drive_cmd_e    cmd;
    } filt_st_t;

    filt_st_t s_d, s_q;
    logic     mid_now;

    assign mid_now = pwm_code[MID_BIT];

    always_comb begin
        s_d = s_q;
        if (mid_now) begin
            if (s_q.cnt != HW'(HOLDOFF_CYC)) begin
                s_d.cnt = s_q.cnt + HW'(1);
            end
            if (s_d.cnt == HW'(HOLDOFF_CYC)) begin
                s_d.cmd = CMD_OFF;
            end
        end else begin
            s_d.cnt = '0;
            s_d.cmd = (pwm_code == PWM_HIGH) ? CMD_HIGH : CMD_LOW;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.cnt <= '0;
            s_q.cmd <= CMD_OFF;
        end else begin
            s_q <= s_d;
        end
    end

    assign cmd = s_q.cmd;

    // R3: a mid excursion shorter than the hold-off keeps the command
    a_r3_short_mid_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (mid_now && (s_q.cnt < HW'(HOLDOFF_CYC - 1))) |=> $stable(cmd));

    // R3: the last hold-off sample parks the command
    a_r3_holdoff_parks: assert property (@(posedge clk) disable iff (!rst_n)
        (mid_now && (s_q.cnt == HW'(HOLDOFF_CYC - 1))) |=> (cmd == CMD_OFF));

    // R4: leaving the window to high takes effect at once
    a_r4_exit_high: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_code == PWM_HIGH) |=> (cmd == CMD_HIGH));

endmodule

// File: rtl/tsg_gate_seq.sv
module tsg_gate_seq #(
    parameter int unsigned HS_ON_CYC = 2,
    parameter int unsigned LS_ON_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic want_hs,
    input  logic want_ls,
    output logic gate_hs,
    output logic gate_ls
);
    localparam int unsigned HWW = $clog2(HS_ON_CYC + 1);
    localparam int unsigned LWW = $clog2(LS_ON_CYC + 1);

    typedef struct packed {
        logic           hs;
        logic           ls;
        logic [HWW-1:0] hs_wait;
        logic [LWW-1:0] ls_wait;
    } seq_st_t;

    seq_st_t s_d, s_q;
    logic    both_off;

    assign both_off = !s_q.hs && !s_q.ls;

    always_comb begin
        s_d = s_q;

        if (want_hs && both_off) begin
            if (s_q.hs_wait != HWW'(HS_ON_CYC)) begin
                s_d.hs_wait = s_q.hs_wait + HWW'(1);
            end
        end else begin
            s_d.hs_wait = '0;
        end

        if (want_ls && both_off) begin
            if (s_q.ls_wait != LWW'(LS_ON_CYC)) begin
                s_d.ls_wait = s_q.ls_wait + LWW'(1);
            end
        end else begin
            s_d.ls_wait = '0;
        end

        if (s_q.hs) begin
            s_d.hs = want_hs;
        end else begin
            s_d.hs = want_hs && both_off && (s_d.hs_wait == HWW'(HS_ON_CYC));
        end

        if (s_q.ls) begin
            s_d.ls = want_ls;
        end else begin
            s_d.ls = want_ls && both_off && (s_d.ls_wait == LWW'(LS_ON_CYC));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign gate_hs = s_q.hs;
    assign gate_ls = s_q.ls;

    // R5: requests from the command decode never collide
    a_r5_requests_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(want_hs && want_ls));

    // R5: no simultaneous conduction
    a_r5_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_hs && gate_ls));

    // R5: high gate rises only after a cycle with the low gate off
    a_r5_hs_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_hs) |-> !$past(gate_ls));

    // R5: low gate rises only after a cycle with the high gate off
    a_r5_ls_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_ls) |-> !$past(gate_hs));

    // R6: a withdrawn request turns the gate off at the next edge
    a_r6_hs_off: assert property (@(posedge clk) disable iff (!rst_n)
        !want_hs |=> !gate_hs);

    a_r6_ls_off: assert property (@(posedge clk) disable iff (!rst_n)
        !want_ls |=> !gate_ls);

endmodule

// File: rtl/tsg_gate_ctrl.sv
module tsg_gate_ctrl
    import tsg_pkg::*;
#(
    parameter int unsigned QUAL_CYC    = 15625,
    parameter int unsigned HOLDOFF_CYC = 3,
    parameter int unsigned HS_ON_CYC   = 2,
    parameter int unsigned LS_ON_CYC   = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] pwm_code,
    input  logic       ls_enable,
    input  logic       hs_inhibit,
    input  logic       supply_ok,
    output logic       gate_hs,
    output logic       gate_ls
);
    logic       ready;
    drive_cmd_e cmd;
    logic       want_hs;
    logic       want_ls;

    tsg_ready_qual #(
        .QUAL_CYC (QUAL_CYC)
    ) u_ready (
        .clk       (clk),
        .rst_n     (rst_n),
        .supply_ok (supply_ok),
        .ready     (ready)
    );

    tsg_mid_filter #(
        .HOLDOFF_CYC (HOLDOFF_CYC)
    ) u_filter (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwm_code (pwm_code),
        .cmd      (cmd)
    );

    always_comb begin
        want_hs = ready && (cmd == CMD_HIGH) && !hs_inhibit;
        want_ls = ready && (cmd == CMD_LOW) && ls_enable;
    end

    tsg_gate_seq #(
        .HS_ON_CYC (HS_ON_CYC),
        .LS_ON_CYC (LS_ON_CYC)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .want_hs (want_hs),
        .want_ls (want_ls),
        .gate_hs (gate_hs),
        .gate_ls (gate_ls)
    );

    // R8: inhibit forces the high gate low after the edge
    a_r8_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
        hs_inhibit |=> !gate_hs);

    // R7: without readiness both gates are off after the next edge
    a_r7_unready_off: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> (!gate_hs && !gate_ls));

    // R2: a high command keeps the low gate off
    a_r2_high_no_ls: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_HIGH) |=> !gate_ls);

    // R1: low side disabled keeps the low gate off
    a_r1_ls_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !ls_enable |=> !gate_ls);

endmodule

// File: tb/sim_tsg_gate_ctrl.sv
module sim_tsg_gate_ctrl;
    localparam int Q    = 20;
    localparam int H    = 3;
    localparam int HSON = 2;
    localparam int LSON = 2;

    logic       clk   = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] pwm   = 2'b00;
    logic       lsen  = 1'b0;
    logic       inh   = 1'b0;
    logic       sup   = 1'b0;
    logic       ghs;
    logic       gls;

    always #4 clk = ~clk;

    tsg_gate_ctrl #(
        .QUAL_CYC    (Q),
        .HOLDOFF_CYC (H),
        .HS_ON_CYC   (HSON),
        .LS_ON_CYC   (LSON)
    ) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwm_code   (pwm),
        .ls_enable  (lsen),
        .hs_inhibit (inh),
        .supply_ok  (sup),
        .gate_hs    (ghs),
        .gate_ls    (gls)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // cycle model of the requirements; command 0 park, 1 low, 2 high
    int m_rc, m_rdy, m_mc, m_cmd, m_hs, m_ls, m_hw, m_lw;

    function automatic int sat_inc(input int v, input int lim);
        return (v >= lim) ? lim : v + 1;
    endfunction

    always @(posedge clk or negedge rst_n) begin : model
        int n_rc, n_rdy, n_mc, n_cmd, n_hs, n_ls, n_hw, n_lw, wh, wl, boff;
        if (!rst_n) begin
            m_rc = 0; m_rdy = 0; m_mc = 0; m_cmd = 0;
            m_hs = 0; m_ls = 0; m_hw = 0; m_lw = 0;
        end else begin
            n_rc  = sup ? sat_inc(m_rc, Q) : 0;
            n_rdy = (sup && n_rc == Q) ? 1 : 0;
            if (pwm[1]) begin
                n_mc  = sat_inc(m_mc, H);
                n_cmd = (n_mc == H) ? 0 : m_cmd;
            end else begin
                n_mc  = 0;
                n_cmd = pwm[0] ? 2 : 1;
            end
            wh   = (m_rdy != 0 && m_cmd == 2 && !inh) ? 1 : 0;
            wl   = (m_rdy != 0 && m_cmd == 1 && lsen) ? 1 : 0;
            boff = (m_hs == 0 && m_ls == 0) ? 1 : 0;
            n_hw = (wh != 0 && boff != 0) ? sat_inc(m_hw, HSON) : 0;
            n_lw = (wl != 0 && boff != 0) ? sat_inc(m_lw, LSON) : 0;
            n_hs = (m_hs != 0) ? wh : ((wh != 0 && boff != 0 && n_hw == HSON) ? 1 : 0);
            n_ls = (m_ls != 0) ? wl : ((wl != 0 && boff != 0 && n_lw == LSON) ? 1 : 0);
            m_rc = n_rc; m_rdy = n_rdy; m_mc = n_mc; m_cmd = n_cmd;
            m_hs = n_hs; m_ls = n_ls; m_hw = n_hw; m_lw = n_lw;
        end
    end

    logic p_hs = 1'b0;
    logic p_ls = 1'b0;

    task automatic chk(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(ghs, (m_hs != 0), "R6 model high gate");
            chk(gls, (m_ls != 0), "R6 model low gate");
            chk(ghs && gls, 1'b0, "R5 no overlap");
            if (ghs && !p_hs) chk(p_ls, 1'b0, "R5 high rise gap");
            if (gls && !p_ls) chk(p_hs, 1'b0, "R5 low rise gap");
            p_hs = ghs;
            p_ls = gls;
        end
    endtask

    initial begin
        void'($urandom(32'd4711));
        tick(3);
        chk(ghs, 1'b0, "R9 reset high gate");
        chk(gls, 1'b0, "R9 reset low gate");
        rst_n = 1'b1;

        // R7 qualification, then R6 turn-on count
        sup = 1'b1; pwm = 2'b01; lsen = 1'b1;
        tick(Q - 1);
        chk(ghs, 1'b0, "R7 off before qualification");
        tick(2);
        chk(ghs, 1'b0, "R6 high waits its count");
        tick(1);
        chk(ghs, 1'b1, "R2 high on after count");

        // steady truth table: R1 R2 R3 R8
        for (int p = 0; p < 4; p++) begin
            for (int e = 0; e < 2; e++) begin
                for (int k = 0; k < 2; k++) begin
                    pwm = p[1:0]; lsen = e[0]; inh = k[0];
                    tick(12);
                    chk(ghs, (p == 1 && k == 0), "R2 R8 steady high gate");
                    chk(gls, (p == 0 && e == 1), "R1 R3 steady low gate");
                end
            end
        end

        // R3 short mid glitch on the high side
        pwm = 2'b01; lsen = 1'b1; inh = 1'b0;
        tick(12);
        pwm = 2'b10;
        tick(1); chk(ghs, 1'b1, "R3 glitch keeps high 1");
        tick(1); chk(ghs, 1'b1, "R3 glitch keeps high 2");
        pwm = 2'b01;
        tick(1); chk(ghs, 1'b1, "R3 glitch keeps high 3");

        // R3 exact hold-off from the low side
        pwm = 2'b00;
        tick(12);
        pwm = 2'b11;
        tick(2); chk(gls, 1'b1, "R3 low held during hold-off");
        tick(1); chk(gls, 1'b1, "R3 park accepted, gate next edge");
        tick(1); chk(gls, 1'b0, "R3 low off after hold-off");
        tick(6);

        // R4 immediate exit to low, then R6 count
        pwm = 2'b00;
        tick(2); chk(gls, 1'b0, "R6 low waits its count");
        tick(1); chk(gls, 1'b1, "R4 low on after exit");

        // R5 break-before-make low to high
        pwm = 2'b01;
        tick(2);
        chk(gls, 1'b0, "R5 low off first");
        chk(ghs, 1'b0, "R5 gap cycle");
        tick(1); chk(ghs, 1'b0, "R5 high still waiting");
        tick(1); chk(ghs, 1'b1, "R5 high on after gap");

        // R8 inhibit while high is on; low side still follows
        inh = 1'b1;
        tick(1); chk(ghs, 1'b0, "R8 inhibit drops high");
        pwm = 2'b00;
        tick(8); chk(gls, 1'b1, "R8 low follows under inhibit");
        inh = 1'b0;

        // R7 supply drop
        sup = 1'b0;
        tick(1); chk(gls, 1'b1, "R7 gate one edge after drop");
        tick(1); chk(gls, 1'b0, "R7 gate off two edges after drop");
        sup = 1'b1;
        tick(Q + 6);
        chk(gls, 1'b1, "R7 low back after requalify");

        // random runs against the model
        for (int c = 0; c < 4000; ) begin
            int run;
            int r;
            run = 1 + int'($urandom_range(7));
            r   = int'($urandom_range(9));
            if (r < 4) pwm = 2'b00;
            else if (r < 8) pwm = 2'b01;
            else pwm = (r == 8) ? 2'b10 : 2'b11;
            lsen = ($urandom_range(5) != 0);
            inh  = ($urandom_range(7) == 0);
            sup  = ($urandom_range(60) != 0);
            tick(run);
            c += run;
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule